// File: doc/BRIEF.md
# Byte Mask and Shuffle Unit

This unit rearranges bytes under a stored permutation. It supports two operations. The mask-set operation adds two 64-bit integer operands and returns the sum as an integer result. It also latches the low 32 bits of that sum into the upper half of a 64-bit graphics status register. The shuffle operation builds a 64-bit vector result. Each of its eight output bytes is taken from the sixteen bytes of the two 64-bit operands, and the choice is made by one 4-bit field of the stored permutation.

The permutation does not travel with the shuffle. Software first issues a mask-set to fix the byte order, then issues any number of shuffles that reuse it. The status register is updated at the same clock edge that registers the mask-set result. A shuffle issued in the very next cycle therefore already uses the new permutation.

Top module: `bmsk_unit`

## Requirements
- R1: A mask-set (op_code 9'h019 with op_valid high) produces int_result = src_a + src_b (modulo 2^64) with int_valid high in the cycle after it is sampled. Otherwise int_valid is low.
- R2: A mask-set writes bits 31:0 of the sum into status bits 63:32 at the same edge. Status bits 31:0 keep their value, which is zero because no operation writes them.
- R3: A shuffle (op_code 9'h04C with op_valid high) produces vec_result with vec_valid high in the cycle after it is sampled. Output byte i (bits 8i+7:8i, i = 0..7) is chosen by permutation field i, which is status bits 32+4i+3:32+4i. Otherwise vec_valid is low.
- R4: A field value n in 0..7 selects byte n of src_a (bits 8n+7:8n). A field value n in 8..15 selects byte n-8 of src_b.
- R5: Reset clears status_reg, int_result and vec_result to zero and drives both valids low. A shuffle before any mask-set therefore returns byte 0 of src_a in every byte position.
- R6: A shuffle sampled in the cycle directly after a mask-set uses the permutation that mask-set loaded.
- R7: Any other op_code, or op_valid low, raises no valid and leaves status_reg, int_result and vec_result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 9 | Operation code: 9'h019 mask-set, 9'h04C shuffle |
| src_a | input | 64 | First operand (integer for mask-set, byte pool 0..7 for shuffle) |
| src_b | input | 64 | Second operand (integer for mask-set, byte pool 8..15 for shuffle) |
| int_result | output | 64 | Registered mask-set sum |
| int_valid | output | 1 | int_result was written this cycle |
| vec_result | output | 64 | Registered shuffle result |
| vec_valid | output | 1 | vec_result was written this cycle |
| status_reg | output | 64 | Status register; bits 63:32 hold the permutation |

## Verification
The hardest case to reach is a shuffle that follows a mask-set with no idle cycle between them. In that case a stale permutation would go unnoticed unless the old and new permutations give different bytes. The stimulus therefore holds op_valid high across two consecutive edges. It switches from mask-set to shuffle between the edges, and the two permutations are chosen so that every output byte differs between them. Random permutations and operands are also compared against a permutation model in the bench that indexes a 16-byte array.

// File: rtl/bmsk_pkg.sv
package bmsk_pkg;
  localparam int WORD_W    = 64;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = WORD_W / BYTE_W;
  localparam int SEL_W     = 4;
  localparam int MASK_W    = NUM_BYTES * SEL_W;
  localparam int OPC_W     = 9;

  localparam logic [OPC_W-1:0] OPC_MASKSET = 9'h019;
  localparam logic [OPC_W-1:0] OPC_SHUFFLE = 9'h04C;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_MASK = 2'd1,
    OP_SHUF = 2'd2
  } op_kind_e;

  // Sum that forms the permutation value
  function automatic logic [WORD_W-1:0] mask_sum(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    return a + b;
  endfunction

  // Select one byte out of the 16-byte pool {b, a}
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] a,
                                                  input logic [WORD_W-1:0] b,
                                                  input logic [SEL_W-1:0]  sel);
    logic [2*WORD_W-1:0] pool;
    pool = {b, a};
    return pool[int'(sel)*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/bmsk_decode.sv
module bmsk_decode
  import bmsk_pkg::*;
(
  input  logic             op_valid,
  input  logic [OPC_W-1:0] op_code,
  output op_kind_e         kind
);
  always_comb begin
    kind = OP_NONE;
    if (op_valid) begin
      if (op_code == OPC_MASKSET)      kind = OP_MASK;
      else if (op_code == OPC_SHUFFLE) kind = OP_SHUF;
    end
  end
endmodule

// File: rtl/bmsk_status.sv
module bmsk_status #(
  parameter int WORD_W = 64,
  parameter int MASK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MASK_W-1:0] load_val,
  output logic [WORD_W-1:0] status_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    status_q <= '0;
    else if (load) status_q[WORD_W-1 -: MASK_W] <= load_val;
  end

  AST_LOW_HALF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> $stable(status_q[WORD_W-MASK_W-1:0])); // R2
endmodule

// File: rtl/bmsk_lane.sv
module bmsk_lane
  import bmsk_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [SEL_W-1:0]  sel,
  output logic [BYTE_W-1:0] byte_out
);
  always_comb byte_out = pick_byte(a, b, sel);
endmodule

// File: rtl/bmsk_unit.sv
module bmsk_unit
  import bmsk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OPC_W-1:0]  op_code,
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  output logic [WORD_W-1:0] int_result,
  output logic              int_valid,
  output logic [WORD_W-1:0] vec_result,
  output logic              vec_valid,
  output logic [WORD_W-1:0] status_reg
);
  op_kind_e          kind;
  logic              mask_fire;
  logic              shuf_fire;
  logic [WORD_W-1:0] sum_w;
  logic [MASK_W-1:0] cur_mask;
  logic [WORD_W-1:0] shuf_w;

  bmsk_decode u_dec (.op_valid(op_valid), .op_code(op_code), .kind(kind));

  assign mask_fire = (kind == OP_MASK);
  assign shuf_fire = (kind == OP_SHUF);
  assign sum_w     = mask_sum(src_a, src_b);

  bmsk_status #(.WORD_W(WORD_W), .MASK_W(MASK_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .load(mask_fire),
    .load_val(sum_w[MASK_W-1:0]), .status_q(status_reg));

  assign cur_mask = status_reg[WORD_W-1 -: MASK_W];

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    bmsk_lane u_lane (
      .a(src_a), .b(src_b),
      .sel(cur_mask[i*SEL_W +: SEL_W]),
      .byte_out(shuf_w[i*BYTE_W +: BYTE_W]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_result <= '0;
      int_valid  <= 1'b0;
      vec_result <= '0;
      vec_valid  <= 1'b0;
    end else begin
      int_valid <= mask_fire;
      vec_valid <= shuf_fire;
      if (mask_fire) int_result <= sum_w;
      if (shuf_fire) vec_result <= shuf_w;
    end
  end

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mask_fire, shuf_fire})); // R7
  AST_INT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    mask_fire |=> int_valid && int_result == $past(src_a) + $past(src_b)); // R1
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_fire |=> status_reg[WORD_W-1 -: MASK_W] == $past(src_a[MASK_W-1:0] + src_b[MASK_W-1:0])); // R2
  AST_VEC_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    shuf_fire |=> vec_valid); // R3
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_fire |=> $stable(status_reg)); // R7
  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_fire && !shuf_fire |=> !int_valid && !vec_valid && $stable(int_result) && $stable(vec_result)); // R7
endmodule

// File: tb/tb_bmsk_unit.sv
module tb_bmsk_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [8:0]  op_code = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [63:0] int_result, vec_result, status_reg;
  logic        int_valid, vec_valid;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [8:0] MSET = 9'h019, SHUF = 9'h04C;

  bmsk_unit dut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .int_result(int_result), .int_valid(int_valid),
    .vec_result(vec_result), .vec_valid(vec_valid), .status_reg(status_reg));

  always #2 clk = ~clk;

  function automatic logic [63:0] ref_shuffle(logic [31:0] m, logic [63:0] a, logic [63:0] b);
    logic [7:0] pool [16];
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) begin
      pool[k] = a[8*k +: 8];
      pool[k+8] = b[8*k +: 8];
    end
    for (int k = 0; k < 8; k++) r[8*k +: 8] = pool[m[4*k +: 4]];
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [8:0] c, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    op_valid = v; op_code = c; src_a = a; src_b = b;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    drive(1'b0, '0, '0, '0);
  endtask

  task automatic t_reset();
    check("R5 status", status_reg, 64'h0);
    check("R5 int_result", int_result, 64'h0);
    check("R5 vec_result", vec_result, 64'h0);
    check("R5 valids", {62'h0, int_valid, vec_valid}, 64'h0);
    drive(1'b1, SHUF, 64'h8877665544332211, 64'hFFEEDDCCBBAA9900);
    check("R5 shuffle before mask-set", vec_result, 64'h1111111111111111);
    idle();
  endtask

  task automatic t_maskset();
    drive(1'b1, MSET, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_7654_3212);
    check("R1 int_valid", {63'h0, int_valid}, 64'h1);
    check("R1 sum wraps", int_result, 64'h0000_0000_7654_3211);
    check("R2 status", status_reg, 64'h7654_3211_0000_0000);
    idle();
    check("R1 int_valid drops", {63'h0, int_valid}, 64'h0);
  endtask

  task automatic t_directed();
    logic [63:0] a = 64'h0706050403020100, b = 64'h0F0E0D0C0B0A0908;
    drive(1'b1, MSET, 64'h76543210, 64'h0);
    drive(1'b1, SHUF, a, b);
    check("R3 vec_valid", {63'h0, vec_valid}, 64'h1);
    check("R4 identity from src_a", vec_result, a);
    drive(1'b1, MSET, 64'hFEDCBA98, 64'h0);
    drive(1'b1, SHUF, a, b);
    check("R4 identity from src_b", vec_result, b);
    drive(1'b1, MSET, 64'h08F71E2D, 64'h0);
    drive(1'b1, SHUF, a, b);
    check("R4 mixed", vec_result, ref_shuffle(32'h08F71E2D, a, b));
    idle();
    check("R3 vec_valid drops", {63'h0, vec_valid}, 64'h0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 40; n++) begin
      logic [63:0] x = {$urandom, $urandom}, y = {$urandom, $urandom};
      logic [63:0] a = {$urandom, $urandom}, b = {$urandom, $urandom};
      logic [63:0] s = x + y;
      drive(1'b1, MSET, x, y);
      check("R1 random sum", int_result, s);
      drive(1'b1, SHUF, a, b);
      check("R3 random shuffle", vec_result, ref_shuffle(s[31:0], a, b));
    end
    idle();
  endtask

  task automatic t_back2back();
    logic [63:0] a = 64'hA7A6A5A4A3A2A1A0, b = 64'hB7B6B5B4B3B2B1B0;
    drive(1'b1, MSET, 64'h01234567, 64'h0);
    idle();
    drive(1'b1, MSET, 64'hCDEF89AB, 64'h0);
    drive(1'b1, SHUF, a, b);
    check("R6 new mask used", vec_result, ref_shuffle(32'hCDEF89AB, a, b));
    idle();
  endtask

  task automatic t_ignore();
    logic [63:0] st = status_reg, ir = int_result, vr = vec_result;
    drive(1'b0, MSET, 64'h1234, 64'h5678);
    check("R7 valid low status", status_reg, st);
    check("R7 valid low outputs", {62'h0, int_valid, vec_valid}, 64'h0);
    drive(1'b0, SHUF, 64'h1234, 64'h5678);
    check("R7 valid low vec", vec_result, vr);
    drive(1'b1, 9'h04D, 64'h1111, 64'h2222);
    check("R7 other opcode status", status_reg, st);
    check("R7 other opcode int", int_result, ir);
    check("R7 other opcode valids", {62'h0, int_valid, vec_valid}, 64'h0);
    drive(1'b1, 9'h119, 64'h1111, 64'h2222);
    check("R7 near opcode status", status_reg, st);
    idle();
  endtask

  initial begin
    #10; @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_maskset();
    t_directed();
    t_random();
    t_back2back();
    t_ignore();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule